// File: doc/BRIEF.md
# Write-Once System Control Register

This block holds a small configuration word for a memory controller. It feeds two consumers. The first is a wait-state counter that holds back the ready signal of an external bus access for zero to three extra clocks. The second is a set of decode qualifiers that put nonvolatile memory into the address map and can keep direct decode away from the fixed pages in the lower half of the map. The word sits on a simple register bus: select, write strobe, write data and combinational read data.

A 2-bit operating-mode input decides two things: the contents loaded at reset, and whether software may rewrite the word freely or only once. Two modes lock the register after one write. The other two accept any number of writes. Every accepted write passes through a one-cycle pending stage before it reaches the read data or any output. Only two modes let the stretch field reach the bus handshake. In the other two, every external access completes at once.

Top module: `sysctl_cfg_reg`

## Requirements
- R1: The read data places the stretch field in bits 3:2, the upper-half-only flag in bit 1 and the memory-enable flag in bit 0. Bits 7:4 always read as zero, whatever was written to them.
- R2: A synchronous reset loads contents that depend on mode_i. Mode 2'b00 (single-chip) and mode 2'b10 (peripheral) load 0x0D. Mode 2'b11 (special test) loads 0x0C. Mode 2'b01 (expanded, also used for emulation) loads 0x0C with bit 0 taken from rom_def_i.
- R3: In modes 2'b00 and 2'b01, only the first write after reset is accepted. Every later write is ignored until the next reset.
- R4: In modes 2'b10 and 2'b11, every write is accepted.
- R5: An accepted write becomes visible on rdata_o and on all outputs in the second cycle after the write cycle. In the cycle directly after the write, the old contents are still read and still drive the outputs.
- R6: In modes 2'b01 and 2'b11, an access whose request starts in cycle t with stretch value N (0 to 3) raises rdy_o in cycle t+N. The requester holds req_i high until rdy_o is seen. For N greater than 0, rdy_o stays low in the start cycle.
- R7: In modes 2'b00 and 2'b10, the stretch field has no effect. rdy_o is high in the same cycle as the request.
- R8: The stretch value is captured when an access starts. A write that changes the field during an access does not change the length of that access.
- R9: mem_en_o equals the effective memory-enable flag (bit 0). win_en_o, the paging-window qualifier, also follows bit 0.
- R10: lo_fixed_en_o is high only when bit 0 is 1 and bit 1 is 0.
- R11: rdy_o is never high while req_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode (00 single-chip, 01 expanded, 10 peripheral, 11 special test) |
| rom_def_i | input | 1 | Reset value of the memory-enable flag in expanded mode |
| sel_i | input | 1 | Register select |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Effective register contents |
| req_i | input | 1 | External access request |
| rdy_o | output | 1 | External access ready |
| mem_en_o | output | 1 | Nonvolatile memory mapped |
| lo_fixed_en_o | output | 1 | Direct decode of lower-half fixed pages allowed |
| win_en_o | output | 1 | Nonvolatile memory reachable through the paging window |

## Verification
Reset contents are checked for every mode, with both levels of rom_def_i. This separates the four reset values and shows that rom_def_i matters only in expanded mode. In both free-write modes, all 256 write values are swept. Each one is checked for the old contents during the delay cycle, then for the masked new contents and the qualifier outputs. This exposes field placement and delay faults. Access length is measured for every stretch value in all four modes, which separates stretching modes from non-stretching modes. Finally, a three-cycle access is overlapped with a write that clears the field, and a double write in each locking mode shows that the lock holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int STRETCH_W = 2;
    localparam int REG_W     = 8;
    localparam int FIELD_W   = STRETCH_W + 2;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_PERIPH   = 2'b10,
        MODE_TEST     = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic [STRETCH_W-1:0] stretch;
        logic                 upper_only;
        logic                 mem_en;
    } cfg_t;

    function automatic logic locks_after_write(op_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_EXPANDED);
    endfunction

    function automatic logic stretch_live(op_mode_e m);
        return (m == MODE_EXPANDED) || (m == MODE_TEST);
    endfunction

    function automatic cfg_t reset_cfg(op_mode_e m, logic rom_def);
        cfg_t c;
        c.stretch    = '1;
        c.upper_only = 1'b0;
        case (m)
            MODE_SINGLE, MODE_PERIPH: c.mem_en = 1'b1;
            MODE_EXPANDED:            c.mem_en = rom_def;
            default:                  c.mem_en = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  op_mode_e mode_i,
    input  logic     rom_def_i,
    input  logic     wr_en_i,
    input  cfg_t     wdata_i,
    output cfg_t     cfg_o
);

    logic locked_q;
    logic pend_vld_q;
    cfg_t pend_q;
    cfg_t cfg_q;
    logic accept;
    logic locking;

    assign locking = locks_after_write(mode_i);
    assign accept  = wr_en_i && !(locking && locked_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q      <= reset_cfg(mode_i, rom_def_i);
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            locked_q   <= 1'b0;
        end else begin
            pend_vld_q <= accept;
            if (accept) begin
                pend_q <= wdata_i;
            end
            if (accept && locking) begin
                locked_q <= 1'b1;
            end
            if (pend_vld_q) begin
                cfg_q <= pend_q;
            end
        end
    end

    assign cfg_o = cfg_q;

    // R3
    lock_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (locked_q && locking && wr_en_i) |=> !pend_vld_q);

    // R5
    delay_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !pend_vld_q) |=> $stable(cfg_q));

endmodule

// File: rtl/sysctl_stretch.sv
module sysctl_stretch #(
    parameter int N_W = 2
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           req_i,
    input  logic [N_W-1:0] n_i,
    output logic           rdy_o
);

    logic           busy_q;
    logic [N_W-1:0] rem_q;
    logic           start;

    assign start = req_i && !busy_q;
    assign rdy_o = busy_q ? (rem_q == '0) : (start && (n_i == '0));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
        end else if (busy_q) begin
            if (rem_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end else if (start && (n_i != '0)) begin
            busy_q <= 1'b1;
            rem_q  <= n_i - 1'b1;
        end
    end

    // R6
    stretch_start_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (start && (n_i != '0)) |-> !rdy_o);

    // R11
    rdy_needs_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rdy_o |-> req_i);

endmodule

// File: rtl/sysctl_qual.sv
module sysctl_qual
    import sysctl_pkg::*;
(
    input  cfg_t cfg_i,
    output logic mem_en_o,
    output logic lo_fixed_en_o,
    output logic win_en_o
);

    assign mem_en_o      = cfg_i.mem_en;
    assign win_en_o      = cfg_i.mem_en;
    assign lo_fixed_en_o = cfg_i.mem_en && !cfg_i.upper_only;

endmodule

// File: rtl/sysctl_cfg_reg.sv
module sysctl_cfg_reg
    import sysctl_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [1:0]  mode_i,
    input  logic        rom_def_i,
    input  logic        sel_i,
    input  logic        wr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic        req_i,
    output logic        rdy_o,
    output logic        mem_en_o,
    output logic        lo_fixed_en_o,
    output logic        win_en_o
);

    localparam int PAD_W = REG_W - FIELD_W;

    op_mode_e             mode;
    cfg_t                 cfg;
    cfg_t                 wcfg;
    logic [STRETCH_W-1:0] n_eff;

    assign mode = op_mode_e'(mode_i);
    assign wcfg = cfg_t'(wdata_i[FIELD_W-1:0]);

    sysctl_store u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode),
        .rom_def_i (rom_def_i),
        .wr_en_i   (sel_i && wr_i),
        .wdata_i   (wcfg),
        .cfg_o     (cfg)
    );

    assign n_eff = stretch_live(mode) ? cfg.stretch : '0;

    sysctl_stretch #(.N_W(STRETCH_W)) u_stretch (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .req_i (req_i),
        .n_i   (n_eff),
        .rdy_o (rdy_o)
    );

    sysctl_qual u_qual (
        .cfg_i         (cfg),
        .mem_en_o      (mem_en_o),
        .lo_fixed_en_o (lo_fixed_en_o),
        .win_en_o      (win_en_o)
    );

    assign rdata_o = {{PAD_W{1'b0}}, cfg};

    // R7
    nostretch_immediate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stretch_live(mode) && req_i) |-> rdy_o);

endmodule

// File: tb/sysctl_cfg_reg_test.sv
module sysctl_cfg_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       rom_def = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       req = 1'b0;
    logic       rdy;
    logic       mem_en, lo_en, win_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    sysctl_cfg_reg uut (
        .clk_i(clk), .rst_i(rst), .mode_i(mode), .rom_def_i(rom_def),
        .sel_i(sel), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
        .req_i(req), .rdy_o(rdy), .mem_en_o(mem_en),
        .lo_fixed_en_o(lo_en), .win_en_o(win_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req_tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic rd);
        tick();
        mode = m; rom_def = rd; rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic wr_start(input logic [7:0] v);
        sel = 1'b1; wr = 1'b1; wdata = v;
        tick();
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic chk_outputs(input string tag, input logic [7:0] v);
        chk(tag, rdata, int'(v & 8'h0F));
        chk({tag, " R9"}, {mem_en, win_en}, {v[0], v[0]});
        chk({tag, " R10"}, lo_en, v[0] & ~v[1]);
    endtask

    task automatic measure(input logic [1:0] m, input logic [1:0] s, input bit mid);
        int k;
        int exp;
        do_reset(m, 1'b1);
        wr_start({4'h0, s, 2'b01});
        tick();
        req = 1'b1;
        #1;
        k = 0;
        while (!rdy && k < 10) begin
            if (k == 0 && mid) begin
                sel = 1'b1; wr = 1'b1; wdata = 8'h01;
            end
            tick();
            sel = 1'b0; wr = 1'b0;
            k++;
        end
        exp = (m[0]) ? int'(s) : 0;
        if (mid) chk("R8 mid-access write", k, exp);
        else if (m[0]) chk("R6 stretch length", k, exp);
        else chk("R7 no stretch", k, exp);
        tick();
        req = 1'b0;
        #1;
        chk("R11 idle ready", rdy, 0);
    endtask

    initial begin
        logic [7:0] prev;
        tick();
        tick();
        rst = 1'b0;

        // R2 reset values, all modes, both rom_def levels
        for (int m = 0; m < 4; m++) begin
            for (int rd = 0; rd < 2; rd++) begin
                int exp;
                do_reset(m[1:0], rd[0]);
                exp = (m == 3) ? 8'h0C : (m == 1) ? (8'h0C | rd) : 8'h0D;
                chk("R2 reset value", rdata, exp);
                chk("R1 reset outputs", {mem_en, lo_en}, {exp[0], exp[0] & ~exp[1]});
            end
        end

        // R4 R5 R1 sweep in free-write modes
        for (int m = 2; m < 4; m++) begin
            do_reset(m[1:0], 1'b0);
            prev = rdata;
            for (int v = 0; v < 256; v++) begin
                wr_start(v[7:0]);
                chk_outputs("R5 old during delay", prev);
                tick();
                chk_outputs("R4 R1 new value", v[7:0]);
                prev = v[7:0] & 8'h0F;
            end
        end

        // R3 write-once in locking modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[1:0], 1'b0);
            wr_start(8'hF6);
            tick();
            chk("R3 first write", rdata, 8'h06);
            wr_start(8'h09);
            tick();
            tick();
            chk("R3 second write ignored", rdata, 8'h06);
            chk("R3 qualifiers unchanged", {mem_en, lo_en}, 2'b00);
        end

        // R6 R7 stretch length over all modes and values
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                measure(m[1:0], s[1:0], 1'b0);
            end
        end

        // R8 change during access
        measure(2'b11, 2'd3, 1'b1);
        measure(2'b11, 2'd2, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule